// File: doc/BRIEF.md
# Residue-Checked Arithmetic Compute Tile

This block is one word-level compute element for a coarse-grained array. Each cycle it may accept two unsigned operands and a three-bit function code. The code chooses multiply, add, subtract, divide, a one-clock relay, or a digit-sum compare. The answer appears on a registered output one clock later, together with a valid strobe and the flags for that answer.

Every arithmetic answer is checked while it is produced, by casting out nines. The tile reduces both operands to their residues modulo 9 and predicts the residue the answer must have. It then reduces the answer itself and raises `res_err` when the two residues disagree. No reference table and no test mode are involved. A fault-injection mask is XORed onto the answer before it is checked and registered, so that a corrupted result can be produced on purpose. Divide-by-zero has a flag of its own, and compare mode reports pass or fail against a digit sum supplied from outside.

Top module: `residue_tile`

## Requirements
- R1: A synchronous active-high reset clears `out_valid`, `result`, `res_err`, `div_zero` and `cmp_pass` at the next rising edge.
- R2: Function codes are MUL=0, ADD=1, SUB=2, DIV=3, RELAY=4 and CMP=5. `out_valid` rises one clock after `in_valid` is sampled high with a code from 0 to 5, and stays low for codes 6 and 7. While `out_valid` is low, all three flags are low.
- R3: In MUL mode, `result` is the full product of `opnd_a` and `opnd_b`, 2·OPND_W bits wide.
- R4: In ADD mode, `result` is the sum of `opnd_a` and `opnd_b`, zero-extended.
- R5: In SUB mode, `result` is `opnd_a - opnd_b` as a two's-complement value sign-extended to 2·OPND_W bits. Its residue is taken as the mod-9 value in the range 0 to 8.
- R6: In DIV mode with a nonzero `opnd_b`, the low OPND_W bits of `result` hold the quotient of `opnd_a` divided by `opnd_b`, and the high OPND_W bits hold the remainder. The check tests that (q·b + r) mod 9 equals a mod 9.
- R7: In DIV mode with `opnd_b` equal to zero, `div_zero` is set, `res_err` stays low, and the uncorrupted result is zero.
- R8: In RELAY mode, `result` is `opnd_a` zero-extended and delayed one clock. An error is flagged if its residue differs from the residue of the operand.
- R9: In CMP mode, `result` is DS(`opnd_a`), where DS(0)=0, a nonzero multiple of 9 gives 9, and any other value n gives n mod 9. `cmp_pass` is high exactly when DS(`opnd_a`) equals `exp_ds`. `res_err` and `div_zero` stay low.
- R10: `flip_mask` is XORed into the computed answer before the check and the output register. `res_err` is high exactly when the residue of the corrupted answer differs from the predicted residue. With a zero mask, `res_err` is never set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and code are presented this cycle |
| op_sel | input | 3 | Function code |
| opnd_a | input | OPND_W | First operand (dividend, relay input, compare input) |
| opnd_b | input | OPND_W | Second operand (divisor) |
| exp_ds | input | 4 | Expected digit sum for compare mode |
| flip_mask | input | 2·OPND_W | Fault-injection XOR mask applied to the answer |
| out_valid | output | 1 | Registered result is valid |
| result | output | 2·OPND_W | Registered answer |
| res_err | output | 1 | Residue check mismatch |
| div_zero | output | 1 | Division by zero |
| cmp_pass | output | 1 | Compare matched |

## Verification
The error flag and the divide-by-zero flag both come from the divide path. Both are evaluated for a corrupted quotient or remainder in the same cycle. The bench therefore runs every operand pair, with the divisor at zero among them, under a single-bit flip mask, and expects `div_zero` high with `res_err` held low. The mismatch flag appears only on divides that have a real divisor. A second overlap comes from the mask and the normal answer sharing the output register. For each corrupted item, the bench recomputes the residue of the flipped value on its own and compares the flag against whether that residue changed.

// File: rtl/rtile_pkg.sv
package rtile_pkg;

  typedef enum logic [2:0] {
    OP_MUL   = 3'd0,
    OP_ADD   = 3'd1,
    OP_SUB   = 3'd2,
    OP_DIV   = 3'd3,
    OP_RELAY = 3'd4,
    OP_CMP   = 3'd5
  } tile_op_e;

  // width of a residue / digit-sum value (0..9)
  localparam int RES_DIGIT_W = 4;
  // width of a residue-domain prediction (8*8+8 = 72 fits)
  localparam int PRED_W = 7;
  // bits folded per step: 2^6 = 64 is 1 mod 9
  localparam int FOLD_W = 6;

  function automatic logic op_is_legal(input logic [2:0] code);
    return code <= 3'd5;
  endfunction

endpackage

// File: rtl/rtile_mod9.sv
// Combinational mod-9 reducer: fold 6-bit chunks (64 = 1 mod 9), then
// restoring subtraction of shifted nines. No table.
module rtile_mod9
  import rtile_pkg::*;
#(
  parameter int IN_W = 4
) (
  input  logic [IN_W-1:0]        val,
  output logic [RES_DIGIT_W-1:0] res
);
  localparam int NCH   = (IN_W + FOLD_W - 1) / FOLD_W;
  localparam int PAD_W = NCH * FOLD_W;
  localparam int ACC_W = $clog2(NCH * ((1 << FOLD_W) - 1) + 1);
  localparam int WRK_W = ACC_W + 4;

  logic [PAD_W-1:0] padded;
  logic [WRK_W-1:0] acc;
  logic [WRK_W-1:0] step;

  always_comb begin
    padded = '0;
    padded[IN_W-1:0] = val;
    acc = '0;
    for (int c = 0; c < NCH; c++) begin
      acc = acc + WRK_W'(padded[c*FOLD_W +: FOLD_W]);
    end
    for (int k = ACC_W - 1; k >= 0; k--) begin
      step = WRK_W'(9) << k;
      if (acc >= step) begin
        acc = acc - step;
      end
    end
    res = acc[RES_DIGIT_W-1:0];
  end

endmodule

// File: rtl/rtile_alu.sv
// Operation datapath: full-precision answers for all six functions.
module rtile_alu
  import rtile_pkg::*;
#(
  parameter int OPND_W = 4
) (
  input  logic [2:0]               op,
  input  logic [OPND_W-1:0]        a,
  input  logic [OPND_W-1:0]        b,
  input  logic [RES_DIGIT_W-1:0]   a_ds,
  output logic [2*OPND_W-1:0]      raw,
  output logic                     dz
);
  localparam int RES_W = 2 * OPND_W;

  always_comb begin
    raw = '0;
    dz  = 1'b0;
    case (tile_op_e'(op))
      OP_MUL:   raw = RES_W'(a) * RES_W'(b);
      OP_ADD:   raw = RES_W'(a) + RES_W'(b);
      OP_SUB:   raw = RES_W'(a) - RES_W'(b);   // wraps = sign-extended
      OP_DIV: begin
        if (b == '0) begin
          dz = 1'b1;                            // R7: answer forced to zero
        end else begin
          raw = {OPND_W'(a % b), OPND_W'(a / b)};
        end
      end
      OP_RELAY: raw = RES_W'(a);
      OP_CMP:   raw = RES_W'(a_ds);
      default:  raw = '0;
    endcase
  end

endmodule

// File: rtl/rtile_check.sv
// Residue checker: predicts the answer's residue from operand residues and
// compares with the residue of the (possibly corrupted) answer.
module rtile_check
  import rtile_pkg::*;
#(
  parameter int OPND_W = 4
) (
  input  logic [2:0]             op,
  input  logic [RES_DIGIT_W-1:0] ra,
  input  logic [RES_DIGIT_W-1:0] rb,
  input  logic [2*OPND_W-1:0]    res_f,
  input  logic                   dz,
  output logic                   err
);
  localparam int RES_W = 2 * OPND_W;

  logic                   neg;
  logic [RES_W-1:0]       mag;
  logic [RES_DIGIT_W-1:0] mag_res;
  logic [RES_DIGIT_W-1:0] act_res;
  logic [RES_DIGIT_W-1:0] q_res;
  logic [RES_DIGIT_W-1:0] r_res;
  logic [PRED_W-1:0]      pred_in;
  logic [RES_DIGIT_W-1:0] pred_res;
  logic [RES_DIGIT_W-1:0] sub_pred;

  // answer residue; only SUB reads the answer as signed (R5)
  assign neg = (tile_op_e'(op) == OP_SUB) && res_f[RES_W-1];
  assign mag = neg ? (-res_f) : res_f;

  rtile_mod9 #(.IN_W(RES_W))  u_mag (.val(mag),                    .res(mag_res));
  rtile_mod9 #(.IN_W(OPND_W)) u_q   (.val(res_f[OPND_W-1:0]),      .res(q_res));
  rtile_mod9 #(.IN_W(OPND_W)) u_r   (.val(res_f[RES_W-1:OPND_W]),  .res(r_res));

  assign act_res = (neg && mag_res != '0) ? (RES_DIGIT_W'(9) - mag_res) : mag_res;

  always_comb begin
    case (tile_op_e'(op))
      OP_MUL:  pred_in = PRED_W'(ra) * PRED_W'(rb);
      OP_ADD:  pred_in = PRED_W'(ra) + PRED_W'(rb);
      OP_DIV:  pred_in = PRED_W'(q_res) * PRED_W'(rb) + PRED_W'(r_res);
      default: pred_in = '0;
    endcase
  end

  rtile_mod9 #(.IN_W(PRED_W)) u_pred (.val(pred_in), .res(pred_res));

  assign sub_pred = (ra >= rb) ? (ra - rb) : (ra + RES_DIGIT_W'(9) - rb);

  // residues are all in 0..8, so 0 and 9 never need separate handling
  always_comb begin
    case (tile_op_e'(op))
      OP_MUL, OP_ADD: err = (act_res != pred_res);
      OP_SUB:         err = (act_res != sub_pred);
      OP_DIV:         err = !dz && (pred_res != ra);   // R7 suppresses
      OP_RELAY:       err = (act_res != ra);
      default:        err = 1'b0;
    endcase
  end

endmodule

// File: rtl/residue_tile.sv
module residue_tile
  import rtile_pkg::*;
#(
  parameter int OPND_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [2:0]             op_sel,
  input  logic [OPND_W-1:0]      opnd_a,
  input  logic [OPND_W-1:0]      opnd_b,
  input  logic [3:0]             exp_ds,
  input  logic [2*OPND_W-1:0]    flip_mask,
  output logic                   out_valid,
  output logic [2*OPND_W-1:0]    result,
  output logic                   res_err,
  output logic                   div_zero,
  output logic                   cmp_pass
);
  localparam int RES_W = 2 * OPND_W;

  logic                              fire;
  logic [1:0][RES_DIGIT_W-1:0]       opnd_res;
  logic [RES_DIGIT_W-1:0]            a_ds;
  logic [RES_W-1:0]                  raw;
  logic [RES_W-1:0]                  res_f;
  logic                              dz_c;
  logic                              err_c;
  logic                              pass_c;

  assign fire = in_valid && op_is_legal(op_sel);

  generate
    for (genvar gi = 0; gi < 2; gi++) begin : g_opres
      rtile_mod9 #(.IN_W(OPND_W)) u_res (
        .val (gi == 0 ? opnd_a : opnd_b),
        .res (opnd_res[gi])
      );
    end
  endgenerate

  // digit sum: nonzero multiples of nine map to 9 (R9)
  assign a_ds = (opnd_res[0] == '0 && opnd_a != '0) ? RES_DIGIT_W'(9) : opnd_res[0];

  rtile_alu #(.OPND_W(OPND_W)) u_alu (
    .op   (op_sel),
    .a    (opnd_a),
    .b    (opnd_b),
    .a_ds (a_ds),
    .raw  (raw),
    .dz   (dz_c)
  );

  assign res_f = raw ^ flip_mask;   // R10 fault injection

  rtile_check #(.OPND_W(OPND_W)) u_chk (
    .op    (op_sel),
    .ra    (opnd_res[0]),
    .rb    (opnd_res[1]),
    .res_f (res_f),
    .dz    (dz_c),
    .err   (err_c)
  );

  assign pass_c = (tile_op_e'(op_sel) == OP_CMP) && (a_ds == exp_ds);

  // R1/R2: result and flags registered together
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      res_err   <= 1'b0;
      div_zero  <= 1'b0;
      cmp_pass  <= 1'b0;
    end else begin
      out_valid <= fire;
      res_err   <= fire && err_c;
      div_zero  <= fire && dz_c;
      cmp_pass  <= fire && pass_c;
      if (fire) begin
        result <= res_f;
      end
    end
  end

endmodule

// File: rtl/residue_tile_props.sv
module residue_tile_props #(
  parameter int OPND_W = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [2:0]          op_sel,
  input logic [OPND_W-1:0]   opnd_a,
  input logic [OPND_W-1:0]   opnd_b,
  input logic [2*OPND_W-1:0] flip_mask,
  input logic                out_valid,
  input logic [2*OPND_W-1:0] result,
  input logic                res_err,
  input logic                div_zero,
  input logic                cmp_pass
);
  localparam int RES_W = 2 * OPND_W;

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always @(negedge clk) begin
    if (rst_q) begin
      assert_reset_clear_R1: assert (!out_valid && result == '0 && !res_err && !div_zero && !cmp_pass);
    end
  end

  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel <= 3'd5) |=> out_valid);

  assert_illegal_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && op_sel <= 3'd5) |=> !out_valid);

  assert_flags_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!res_err && !div_zero && !cmp_pass));

  assert_divzero_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 3'd3 && opnd_b == '0) |=>
      (div_zero && !res_err && result == $past(flip_mask)));

  assert_relay_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 3'd4) |=>
      (result == ($past(RES_W'(opnd_a)) ^ $past(flip_mask))));

  assert_cmp_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 3'd5) |=> (!res_err && !div_zero));

  assert_clean_no_err_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && flip_mask == '0) |=> !res_err);

endmodule

bind residue_tile residue_tile_props #(.OPND_W(OPND_W)) u_props (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .op_sel    (op_sel),
  .opnd_a    (opnd_a),
  .opnd_b    (opnd_b),
  .flip_mask (flip_mask),
  .out_valid (out_valid),
  .result    (result),
  .res_err   (res_err),
  .div_zero  (div_zero),
  .cmp_pass  (cmp_pass)
);

// File: tb/residue_tile_test.sv
`timescale 1ns/1ps
module residue_tile_test;
  localparam int W  = 4;
  localparam int RW = 2 * W;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [2:0]    op_sel;
  logic [W-1:0]  opnd_a, opnd_b;
  logic [3:0]    exp_ds;
  logic [RW-1:0] flip_mask;
  logic          out_valid;
  logic [RW-1:0] result;
  logic          res_err, div_zero, cmp_pass;

  always #2 clk = ~clk;   // 250 MHz

  residue_tile #(.OPND_W(W)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .exp_ds(exp_ds), .flip_mask(flip_mask),
    .out_valid(out_valid), .result(result), .res_err(res_err),
    .div_zero(div_zero), .cmp_pass(cmp_pass)
  );

  typedef struct packed {
    logic          v;
    logic [RW-1:0] res;
    logic          err;
    logic          dz;
    logic          pass;
    logic [7:0]    req;
  } exp_t;

  exp_t sb[$];
  int   n_run = 0;
  int   n_fail = 0;
  logic mon_en = 1'b0;

  function automatic int ds9(int n);
    if (n == 0) return 0;
    return (n % 9 == 0) ? 9 : n % 9;
  endfunction

  function automatic int smod9(int n);
    return ((n % 9) + 9) % 9;
  endfunction

  task automatic chk(logic ok, int req, int act, int expv, string what);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // driver: build expectation from the requirements, push it, drive inputs
  task automatic drive(int op, int a, int b, int e, int mask, int vld, int tag);
    exp_t x;
    int   raw, f, sv;
    x = '0;
    x.v = (vld != 0) && (op <= 5);
    raw = 0;
    case (op)
      0: x.req = 3;   // R3 multiply
      1: x.req = 4;   // R4 add
      2: x.req = 5;   // R5 subtract
      3: x.req = (b == 0) ? 7 : 6;   // R6 divide, R7 divide by zero
      4: x.req = 8;   // R8 relay
      5: x.req = 9;   // R9 compare
      default: x.req = 2;   // R2 illegal code
    endcase
    if (tag != 0) x.req = 8'(tag);
    if (x.v) begin
      case (op)
        0: raw = a * b;
        1: raw = a + b;
        2: raw = (a - b) & 255;
        3: raw = (b == 0) ? 0 : (((a % b) << W) | (a / b));
        4: raw = a;
        default: raw = ds9(a);
      endcase
      f = raw ^ mask;
      x.res = RW'(f);
      case (op)
        0: x.err = (f % 9) != ((a * b) % 9);
        1: x.err = (f % 9) != ((a + b) % 9);
        2: begin
          sv = (f >= 128) ? f - 256 : f;
          x.err = smod9(sv) != smod9(a - b);
        end
        3: begin
          x.dz  = (b == 0);
          x.err = (b != 0) && ((((f & 15) * b + (f >> W)) % 9) != (a % 9));
        end
        4: x.err = (f % 9) != (a % 9);
        default: x.pass = (ds9(a) == e);
      endcase
    end
    @(posedge clk);
    #1;
    in_valid  = (vld != 0);
    op_sel    = 3'(op);
    opnd_a    = W'(a);
    opnd_b    = W'(b);
    exp_ds    = 4'(e);
    flip_mask = RW'(mask);
    if (mon_en) sb.push_back(x);
  endtask

  // monitor: pop one expectation per captured cycle, compare away from edge
  initial begin
    forever begin
      int   n;
      exp_t x;
      @(posedge clk);
      n = sb.size();
      @(negedge clk);
      if (n > 0) begin
        x = sb.pop_front();
        n_run++;
        if (out_valid !== x.v ||
            (x.v && (result !== x.res || res_err !== x.err ||
                     div_zero !== x.dz || cmp_pass !== x.pass)) ||
            (!x.v && (res_err || div_zero || cmp_pass))) begin
          n_fail++;
          $display("FAIL R%0d a=%0d b=%0d op=%0d: actual v=%0b res=%0d err=%0b dz=%0b pass=%0b expected v=%0b res=%0d err=%0b dz=%0b pass=%0b",
                   x.req, opnd_a, opnd_b, op_sel, out_valid, result, res_err, div_zero, cmp_pass,
                   x.v, x.res, x.err, x.dz, x.pass);
        end
      end
    end
  end

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b1; op_sel = 3'd0; opnd_a = '1; opnd_b = '1;
    exp_ds = '0; flip_mask = '0;
    // R1: reset dominates a valid request
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, 1, int'(out_valid), 0, "valid in reset");
    chk(result == '0, 1, int'(result), 0, "result in reset");
    chk({res_err, div_zero, cmp_pass} == 3'b000, 1, int'({res_err, div_zero, cmp_pass}), 0, "flags in reset");
    @(posedge clk); #1;
    rst = 1'b0; in_valid = 1'b0;
    mon_en = 1'b1;

    // R3..R9 exhaustive, clean answers
    for (int op = 0; op < 6; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          drive(op, a, b, (b < 10) ? b : ds9(a), 0, 1, 0);

    // R10 single-bit flips over every mode and pair
    for (int op = 0; op < 6; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          drive(op, a, b, b % 10, 1 << ((a * 3 + b + op) % RW), 1, 10);

    // R10 multi-bit flips that preserve or break residue
    drive(0, 3, 3, 0, 8'h09, 1, 10);
    drive(1, 15, 15, 0, 8'h1B, 1, 10);
    drive(2, 0, 15, 0, 8'hFF, 1, 10);

    // R2 illegal codes and idle cycles
    drive(6, 5, 5, 0, 0, 1, 2);
    drive(7, 9, 3, 0, 0, 1, 2);
    drive(0, 7, 7, 0, 8'h01, 0, 2);
    drive(1, 2, 2, 0, 0, 1, 0);
    drive(3, 9, 0, 0, 0, 0, 2);
    wait (sb.size() == 0);
    mon_en = 1'b0;
    repeat (2) @(posedge clk);

    // R1: reset mid-stream clears a held result
    #1; in_valid = 1'b1; op_sel = 3'd0; opnd_a = 4'd15; opnd_b = 4'd15; flip_mask = '0;
    @(posedge clk); #1;
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    chk(out_valid && result == 8'd225, 1, int'(result), 225, "product before reset");
    @(negedge clk);
    chk(!out_valid && result == '0, 1, int'(result), 0, "cleared by reset");
    rst = 1'b0;
    repeat (2) @(posedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule